// File: doc/BRIEF.md
# Serial Nonvolatile Memory Bit-Bang Port

An 8-bit control register through which software reaches two serial nonvolatile memory chips, one bit transition per write. The chips share one serial data-in and one serial clock field. Each chip has its own select bit, so software chooses which chips receive each transition. The same register also holds two board-level bits: a power-on indicator and a system power enable. Both appear directly on output pins.

Every write applies the select bits and the power and indicator bits. The data and clock bits reach only the chips whose select bit is set in that same write. A chip that is not selected keeps the data and clock levels it was last given. A read returns the stored control bits. Bit 0 of the read value is the shared serial data-out line coming back from the memories, not the value that was written. The register sits on a simple synchronous bus: a write takes one cycle when the byte strobe is high, and read data is combinational from the stored state.

Top module: `nvbb_port`

## Requirements
- R1: While rst_ni is low and after it is released, every stored bit is zero, so rd_data_o, mem_cs_o, mem_di_o, mem_sk_o, led_o and pwr_en_o all read zero until the first write.
- R2: A write (wr_en_i high at a rising clock edge) stores wr_data_i[5:1]. From the next cycle, rd_data_o[5:1] equals those bits.
- R3: wr_data_i[0] is never stored. After a write, rd_data_o[0] shows the data-out line whatever value was written in bit 0.
- R4: rd_data_o[0] equals the value of sdo_i at the previous rising clock edge, on every cycle, with or without a write.
- R5: mem_cs_o[k] equals the stored select bit wr_data_i[2+k] from the most recent write (k = 0, 1). It changes in the cycle after that write.
- R6: On a write with wr_data_i[2+k] set, mem_di_o[k] takes wr_data_i[0] and mem_sk_o[k] takes wr_data_i[1] from the next cycle.
- R7: On a write with wr_data_i[2+k] clear, mem_di_o[k] and mem_sk_o[k] keep their previous levels.
- R8: led_o equals stored bit 4 and pwr_en_o equals stored bit 5.
- R9: rd_data_o[7:6] always read zero.
- R10: In a cycle without a write, rd_data_o[5:1] and all chip outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data: stored bits 5:1, captured data-out line in bit 0 |
| sdo_i | input | 1 | Shared serial data-out line from the memories |
| mem_cs_o | output | 2 | Select line to each memory |
| mem_di_o | output | 2 | Serial data-in to each memory |
| mem_sk_o | output | 2 | Serial clock to each memory |
| led_o | output | 1 | Power-on indicator |
| pwr_en_o | output | 1 | System power enable |

## Verification
A lane whose hold logic is wrong shows up as an unselected memory seeing a clock or data edge. It is visible on mem_sk_o or mem_di_o in the cycle after the write that should have left that lane alone. A wrong stored field shows on rd_data_o, led_o or pwr_en_o one cycle after the write. A broken data-out capture makes rd_data_o[0] differ from the previous cycle's sdo_i on the very next cycle. The reference model compares every output on every clock, so each of these faults is reported within one cycle of its cause.

// File: rtl/nvbb_pkg.sv
package nvbb_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned DAT_BIT = 0;
  localparam int unsigned CLK_BIT = 1;
  localparam int unsigned CS_BASE = 2;
endpackage

// File: rtl/nvbb_ctrl_reg.sv
module nvbb_ctrl_reg
  import nvbb_pkg::*;
#(
  parameter int unsigned HI = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [HI:1]      wr_field_i,
  input  logic             sdo_i,
  output logic [HI:1]      field_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic [HI:1] field_q;
  logic        sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      sdo_q   <= 1'b0;
    end else begin
      sdo_q <= sdo_i;
      if (wr_en_i) field_q <= wr_field_i;
    end
  end

  always_comb begin
    rd_data_o        = '0;
    rd_data_o[HI:1]  = field_q;
    rd_data_o[0]     = sdo_q;
  end

  assign field_o = field_q;
endmodule

// File: rtl/nvbb_lane.sv
module nvbb_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic sel_i,
  input  logic din_i,
  input  logic sck_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_o
);
  logic cs_q, di_q, sk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q <= 1'b0;
      di_q <= 1'b0;
      sk_q <= 1'b0;
    end else if (wr_en_i) begin
      // forward select only on a change
      if (sel_i != cs_q) cs_q <= sel_i;
      if (sel_i) begin
        di_q <= din_i;
        sk_q <= sck_i;
      end
    end
  end

  assign cs_o = cs_q;
  assign di_o = di_q;
  assign sk_o = sk_q;
endmodule

// File: rtl/nvbb_port.sv
module nvbb_port
  import nvbb_pkg::*;
#(
  parameter int unsigned N_DEV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             sdo_i,
  output logic [N_DEV-1:0] mem_cs_o,
  output logic [N_DEV-1:0] mem_di_o,
  output logic [N_DEV-1:0] mem_sk_o,
  output logic             led_o,
  output logic             pwr_en_o
);
  localparam int unsigned LED_BIT = CS_BASE + N_DEV;
  localparam int unsigned PWR_BIT = LED_BIT + 1;
  localparam int unsigned HI      = PWR_BIT;

  logic [HI:1] field;
  logic        unused_hi;

  assign unused_hi = ^wr_data_i[REG_W-1:HI+1];

  nvbb_ctrl_reg #(.HI(HI)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_field_i (wr_data_i[HI:1]),
    .sdo_i      (sdo_i),
    .field_o    (field),
    .rd_data_o  (rd_data_o)
  );

  for (genvar k = 0; k < N_DEV; k++) begin : g_lane
    nvbb_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .sel_i   (wr_data_i[CS_BASE+k]),
      .din_i   (wr_data_i[DAT_BIT]),
      .sck_i   (wr_data_i[CLK_BIT]),
      .cs_o    (mem_cs_o[k]),
      .di_o    (mem_di_o[k]),
      .sk_o    (mem_sk_o[k])
    );
  end

  assign led_o    = field[LED_BIT];
  assign pwr_en_o = field[PWR_BIT];
endmodule

// File: rtl/nvbb_chk.sv
module nvbb_chk
  import nvbb_pkg::*;
#(
  parameter int unsigned N_DEV = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             sdo_i,
  input logic [N_DEV-1:0] mem_cs_o,
  input logic [N_DEV-1:0] mem_di_o,
  input logic [N_DEV-1:0] mem_sk_o,
  input logic             led_o,
  input logic             pwr_en_o
);
  localparam int unsigned LED_BIT = CS_BASE + N_DEV;
  localparam int unsigned PWR_BIT = LED_BIT + 1;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  p_rst_zero_r1: assert property (@(posedge clk_i) !rst_ni |-> rd_data_o == '0 && mem_cs_o == '0);

  p_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[PWR_BIT:1] == $past(wr_data_i[PWR_BIT:1]));

  p_sdo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> rd_data_o[0] == $past(sdo_i));

  p_side_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == rd_data_o[LED_BIT] && pwr_en_o == rd_data_o[PWR_BIT]);

  p_hi_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:PWR_BIT+1] == '0);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[PWR_BIT:1]) && $stable(mem_cs_o) && $stable(mem_di_o) && $stable(mem_sk_o));

  for (genvar k = 0; k < N_DEV; k++) begin : g_k
    p_cs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_cs_o[k] == rd_data_o[CS_BASE+k]);
    p_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_data_i[CS_BASE+k] |=>
        mem_di_o[k] == $past(wr_data_i[DAT_BIT]) && mem_sk_o[k] == $past(wr_data_i[CLK_BIT]));
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_data_i[CS_BASE+k] |=> $stable(mem_di_o[k]) && $stable(mem_sk_o[k]));
  end
endmodule

bind nvbb_port nvbb_chk #(.N_DEV(N_DEV)) u_chk (.*);

// File: tb/tb_nvbb_port.sv
`timescale 1ns/1ps
module tb_nvbb_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wd = '0;
  logic       sdo = 1'b0;
  logic [7:0] rd;
  logic [1:0] cs, di, sk;
  logic       led, pwr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nvbb_port dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd),
    .sdo_i(sdo), .mem_cs_o(cs), .mem_di_o(di), .mem_sk_o(sk),
    .led_o(led), .pwr_en_o(pwr)
  );

  // behavioural reference state
  int m_fields, m_bit0;
  int m_cs[2], m_di[2], m_sk[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fields = 0; m_bit0 = 0;
      for (int k = 0; k < 2; k++) begin m_cs[k] = 0; m_di[k] = 0; m_sk[k] = 0; end
    end else begin
      m_bit0 = sdo;
      if (we) begin
        m_fields = (wd >> 1) & 31;
        for (int k = 0; k < 2; k++) begin
          m_cs[k] = (wd >> (2 + k)) & 1;
          if (m_cs[k] != 0) begin
            m_di[k] = wd & 1;
            m_sk[k] = (wd >> 1) & 1;
          end
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 rd[5:1]", int'(rd[5:1]), m_fields);
    check("R4 rd[0]", int'(rd[0]), m_bit0);
    check("R9 rd[7:6]", int'(rd[7:6]), 0);
    check("R8 led", int'(led), (m_fields >> 3) & 1);
    check("R8 pwr", int'(pwr), (m_fields >> 4) & 1);
    for (int k = 0; k < 2; k++) begin
      check("R5 cs", int'(cs[k]), m_cs[k]);
      check("R6 di", int'(di[k]), m_di[k]);
      check("R6 sk", int'(sk[k]), m_sk[k]);
    end
  end

  task automatic cyc(bit w, logic [7:0] d, bit s);
    @(posedge clk); #2;
    we = w; wd = d; sdo = s;
    @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    sdo = 1'b1; wd = 8'hff; we = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rd", int'(rd), 0);
    check("R1 pins", int'({cs, di, sk, led, pwr}), 0);
    we = 1'b0; sdo = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 8'h00, 0);
    check("R1 after release", int'(rd), 0);

    // all set, bit0 written 1 while data-out low
    cyc(1, 8'h3f, 0);
    cyc(0, 8'h00, 1);
    check("R3 bit0 not stored", int'(rd), 8'h3e);
    check("R8 led/pwr", int'({led, pwr}), 3);
    check("R6 di/sk both", int'({di, sk}), 4'hf);
    // select 0 only, drive data 0 clock 0
    cyc(1, 8'h04, 0);
    check("R4 bit0 follows line", int'(rd[0]), 1);
    cyc(0, 8'h00, 0);
    check("R7 lane1 held", int'({di[1], sk[1]}), 3);
    check("R6 lane0 driven", int'({di[0], sk[0]}), 0);
    check("R5 cs", int'(cs), 1);
    // idle cycles with line toggling
    for (int i = 0; i < 4; i++) cyc(0, 8'hff, i[0]);
    check("R10 idle hold", int'({rd[5:1], cs, di, sk}), int'({5'h02, 2'b01, 2'b10, 2'b10}));
    // select 1 only, clock high, data low
    cyc(1, 8'h0a, 0);
    cyc(0, 8'h00, 0);
    check("R7 lane0 held", int'({di[0], sk[0]}), 0);
    check("R6 lane1 clock", int'({di[1], sk[1]}), 1);
    check("R5 cs swap", int'(cs), 2);

    for (int i = 0; i < 400; i++) cyc(1'($urandom), 8'($urandom), 1'($urandom));
    cyc(0, 8'h00, 0);
    summary();
  end
endmodule